// File: doc/BRIEF.md
# Arithmetic Condition Flag Generator

This block derives the carry and overflow status bits that follow an addition, a subtraction or a subtract-with-carry. It is given the two operand words, the result word that an external adder produced and an incoming carry bit. It does no arithmetic on the datapath itself. The zero and negative flags, the register file and instruction decode are handled elsewhere. A two-bit operation select picks the rule, and a fourth select code leaves the flags as they are.

The block also has three small helpers on the first operand. It sign-extends the low 8 bits and the low 16 bits to the full word width, and it brings out the operand's most significant bit as a sign indication. A flag register captures the freshly computed carry and overflow on any clock edge where the update strobe is high. The latched values can then be compared with a reference model during simulation.

Operation select encoding: 2'b00 is addition, 2'b01 is subtraction, 2'b10 is subtract-with-carry, and 2'b11 is hold.

Top module: `flag_gen`

## Requirements
- R1: With op_sel 2'b00, carry_o is 1 exactly when opa[W-1] + opb[W-1], added as a 2-bit sum, is greater than res[W-1].
- R2: With op_sel 2'b01, carry_o is 1 exactly when opa >= opb, both taken as unsigned. Equal operands give 1.
- R3: With op_sel 2'b10, carry_o is 1 exactly when the zero-extended opa is at least the zero-extended opb plus cin. The sum is evaluated at W+1 bits, so all-ones minus all-ones with cin=1 gives 0.
- R4: With op_sel 2'b00, ovf_o is 1 when opa and opb have the same top bit and res's top bit differs from opa's.
- R5: With op_sel 2'b01 or 2'b10, ovf_o is 1 when opa and opb differ in their top bit and res's top bit differs from opa's.
- R6: sext8_o is opa[7:0] with bit 7 copied into every higher bit. sext16_o is opa[15:0] with bit 15 copied into every higher bit.
- R7: sign_o equals opa[W-1].
- R8: On a rising clock edge where upd is 1 and op_sel is not 2'b11, carry_q and ovf_q take the values that carry_o and ovf_o showed before that edge.
- R9: On a rising edge where upd is 0, carry_q and ovf_q keep their values.
- R10: With op_sel 2'b11, carry_o and ovf_o present carry_q and ovf_q. An update edge then leaves both registered flags unchanged.
- R11: While rst_n is low, carry_q and ovf_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 2 | Operation: 00 add, 01 sub, 10 sub-with-carry, 11 hold |
| upd | input | 1 | Strobe that loads the flag register |
| opa | input | W | First operand (minuend for subtraction) |
| opb | input | W | Second operand |
| res | input | W | Result word from the external adder |
| cin | input | 1 | Incoming carry for subtract-with-carry |
| carry_o | output | 1 | Combinational carry flag |
| ovf_o | output | 1 | Combinational overflow flag |
| carry_q | output | 1 | Registered carry flag |
| ovf_q | output | 1 | Registered overflow flag |
| sext8_o | output | W | opa sign-extended from 8 bits |
| sext16_o | output | W | opa sign-extended from 16 bits |
| sign_o | output | 1 | Top bit of opa |

## Verification
The bench uses the default W of 32. At that width the subtract-with-carry case with opa = opb = 0xFFFFFFFF and cin = 1 needs the extra 33rd bit; a 32-bit-only compare would get it wrong. The 32-bit width also makes the 0x7FFFFFFF and 0x80000000 boundaries meaningful for the overflow rules. Both narrow-width extensions leave a non-trivial span of upper bits to fill, so a wrong fill is visible.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_SBC  = 2'b10,
        OP_HOLD = 2'b11
    } op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/flag_carry.sv
module flag_carry
    import flag_gen_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         cin,
    output logic         carry
);
    localparam int XW = W + 1;

    logic [1:0]    top_sum;
    logic [XW-1:0] diff;
    logic          cin_eff;

    always_comb begin
        cin_eff = (op == OP_SBC) ? cin : 1'b0;
        top_sum = {1'b0, a[W-1]} + {1'b0, b[W-1]};
        // Widened difference: its sign bit is the borrow.
        diff    = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin_eff};
        unique case (op)
            OP_ADD:         carry = top_sum > {1'b0, r[W-1]};
            OP_SUB, OP_SBC: carry = ~diff[XW-1];
            default:        carry = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_ovf.sv
module flag_ovf
    import flag_gen_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic         a_msb,
    input  logic         b_msb,
    input  logic         r_msb,
    output logic         ovf
);
    logic ab_diff;
    logic ar_diff;

    always_comb begin
        ab_diff = a_msb ^ b_msb;
        ar_diff = a_msb ^ r_msb;
        unique case (op)
            OP_ADD:         ovf = ~ab_diff & ar_diff;
            OP_SUB, OP_SBC: ovf =  ab_diff & ar_diff;
            default:        ovf = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_sext.sv
module flag_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int FILL_W = OUT_W - IN_W;

    generate
        if (FILL_W > 0) begin : g_fill
            assign dout = {{FILL_W{din[IN_W-1]}}, din};
        end else begin : g_pass
            assign dout = din[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/flag_gen.sv
module flag_gen
    import flag_gen_pkg::*;
#(
    parameter int W      = 32,
    parameter int NARROW_A = 8,
    parameter int NARROW_B = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op_sel,
    input  logic         upd,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] res,
    input  logic         cin,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         carry_q,
    output logic         ovf_q,
    output logic [W-1:0] sext8_o,
    output logic [W-1:0] sext16_o,
    output logic         sign_o
);
    op_e    op;
    logic   carry_new;
    logic   ovf_new;
    flags_t flags_now;
    flags_t flags_d;
    flags_t flags_q;

    assign op = op_e'(op_sel);

    flag_carry #(.W(W)) u_carry (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .r     (res),
        .cin   (cin),
        .carry (carry_new)
    );

    flag_ovf #(.W(W)) u_ovf (
        .op    (op),
        .a_msb (opa[W-1]),
        .b_msb (opb[W-1]),
        .r_msb (res[W-1]),
        .ovf   (ovf_new)
    );

    flag_sext #(.IN_W(NARROW_A), .OUT_W(W)) u_sext_a (
        .din  (opa[NARROW_A-1:0]),
        .dout (sext8_o)
    );

    flag_sext #(.IN_W(NARROW_B), .OUT_W(W)) u_sext_b (
        .din  (opa[NARROW_B-1:0]),
        .dout (sext16_o)
    );

    always_comb begin
        if (op == OP_HOLD) begin
            flags_now = flags_q;
        end else begin
            flags_now.carry = carry_new;
            flags_now.ovf   = ovf_new;
        end
        flags_d = upd ? flags_now : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign carry_o = flags_now.carry;
    assign ovf_o   = flags_now.ovf;
    assign carry_q = flags_q.carry;
    assign ovf_q   = flags_q.ovf;
    assign sign_o  = opa[W-1];
endmodule

// File: rtl/flag_gen_chk.sv
module flag_gen_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   op_sel,
    input logic         upd,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [W-1:0] res,
    input logic         carry_o,
    input logic         ovf_o,
    input logic         carry_q,
    input logic         ovf_q,
    input logic [W-1:0] sext8_o,
    input logic         sign_o
);
    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 2'b00 |-> carry_o == ((opa[W-1] & opb[W-1]) |
                                        ((opa[W-1] ^ opb[W-1]) & ~res[W-1]))); // R1
    AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 2'b01 |-> carry_o == (opa >= opb)); // R2
    AST_SUB_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01 && opa[W-1] == opb[W-1]) |-> !ovf_o); // R5
    AST_SEXT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sext8_o[W-1] == opa[7]); // R6
    AST_SIGN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sign_o == opa[W-1]); // R7
    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel != 2'b11) |=> (carry_q == $past(carry_o) && ovf_q == $past(ovf_o))); // R8
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(carry_q) && $stable(ovf_q))); // R9
    AST_HOLD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 2'b11 |=> ($stable(carry_q) && $stable(ovf_q))); // R10
endmodule

bind flag_gen flag_gen_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .upd     (upd),
    .opa     (opa),
    .opb     (opb),
    .res     (res),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .carry_q (carry_q),
    .ovf_q   (ovf_q),
    .sext8_o (sext8_o),
    .sign_o  (sign_o)
);

// File: tb/flag_gen_tb.sv
module flag_gen_tb;
    localparam int W = 32;

    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] r;
        logic         cin;
        logic         exp_c;
        logic         exp_v;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 32'h0000_0001, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b0, 1'b0}, // R1 R4
        '{2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1, 1'b0}, // R1
        '{2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b0, 1'b1}, // R4
        '{2'b00, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b1}, // R1 R4
        '{2'b01, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 1'b0, 1'b1, 1'b0}, // R2
        '{2'b01, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0}, // R2
        '{2'b01, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1}, // R2 R5
        '{2'b01, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b1, 1'b0}, // R2 equal
        '{2'b10, 32'h0000_0005, 32'h0000_0005, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0}, // R3
        '{2'b10, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0, 1'b1, 1'b0}, // R3
        '{2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0}, // R3 wide
        '{2'b10, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0}, // R3
        '{2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b0, 1'b1}  // R3 R5
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         upd = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] res = '0;
    logic         cin = 1'b0;
    logic         carry_o, ovf_o, carry_q, ovf_q, sign_o;
    logic [W-1:0] sext8_o, sext16_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flag_gen #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .upd(upd),
        .opa(opa), .opb(opb), .res(res), .cin(cin),
        .carry_o(carry_o), .ovf_o(ovf_o), .carry_q(carry_q), .ovf_q(ovf_q),
        .sext8_o(sext8_o), .sext16_o(sext16_o), .sign_o(sign_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset carry", W'(carry_q), '0);
        check("R11 reset ovf", W'(ovf_q), '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = VECS[i].op; opa = VECS[i].a; opb = VECS[i].b;
            res = VECS[i].r; cin = VECS[i].cin; upd = 1'b1;
            #1;
            check("R1-5 comb carry", W'(carry_o), W'(VECS[i].exp_c));
            check("R4/R5 comb ovf", W'(ovf_o), W'(VECS[i].exp_v));
            @(negedge clk);
            check("R8 latched carry", W'(carry_q), W'(VECS[i].exp_c));
            check("R8 latched ovf", W'(ovf_q), W'(VECS[i].exp_v));
        end

        // Load c=1 v=1, then idle with a c=0 v=0 stimulus: R9
        op_sel = 2'b00; opa = 32'h8000_0000; opb = 32'h8000_0000; res = '0; upd = 1'b1;
        @(negedge clk);
        op_sel = 2'b00; opa = 32'h1; opb = 32'h1; res = 32'h2; upd = 1'b0;
        @(negedge clk);
        check("R9 idle carry", W'(carry_q), W'(1'b1));
        check("R9 idle ovf", W'(ovf_q), W'(1'b1));

        // Hold op with update: R10
        op_sel = 2'b11; upd = 1'b1;
        #1;
        check("R10 hold comb carry", W'(carry_o), W'(1'b1));
        check("R10 hold comb ovf", W'(ovf_o), W'(1'b1));
        @(negedge clk);
        check("R10 hold carry_q", W'(carry_q), W'(1'b1));
        check("R10 hold ovf_q", W'(ovf_q), W'(1'b1));
        upd = 1'b0;

        // Sign extension and sign bit: R6 R7
        opa = 32'h1234_5680; #1;
        check("R6 sext8 neg", sext8_o, 32'hFFFF_FF80);
        check("R6 sext16 pos", sext16_o, 32'h0000_5680);
        check("R7 sign pos", W'(sign_o), '0);
        opa = 32'hF000_807F; #1;
        check("R6 sext8 pos", sext8_o, 32'h0000_007F);
        check("R6 sext16 neg", sext16_o, 32'hFFFF_807F);
        check("R7 sign neg", W'(sign_o), W'(1'b1));

        // Mid-run reset: R11
        @(negedge clk);
        rst_n = 1'b0; #1;
        check("R11 async clear carry", W'(carry_q), '0);
        check("R11 async clear ovf", W'(ovf_q), '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule